// File: doc/BRIEF.md
# SHA-256 Four-Lane Message Pre-Schedule Unit

This unit performs the first half of the SHA-256 message-schedule recurrence for four consecutive schedule words in one operation. Operand A supplies four adjacent 32-bit words, with the oldest word in the lowest dword. Only the low dword of operand B is read, and it supplies the word that follows them. Each of the four result lanes is the lane's own word plus the small sigma-0 function of the next word up. The top lane takes its neighbour from operand B.

The datapath is purely combinational and sits behind a single register stage. An input accepted with `valid_in` produces the packed 128-bit result on the next clock, flagged by a one-cycle `valid_out`. A later step, outside this block, finishes the schedule word by adding the sigma-1 term and the W[t-7] term.

Top module: `msg_presched4`

## Requirements
- R1: sigma0(x) = rotr(x,7) XOR rotr(x,18) XOR (x >> 3), with a logical shift on a 32-bit word.
- R2: Lane i (i = 0,1,2) of the result, at bits 32i+31:32i, equals A[32i+31:32i] + sigma0(A[32i+63:32i+32]) modulo 2^32.
- R3: Result bits 127:96 equal A[127:96] + sigma0(B[31:0]) modulo 2^32.
- R4: Each lane wraps modulo 2^32, and no carry passes into the lane above.
- R5: Bits 127:32 of operand B have no effect on the result.
- R6: `valid_out` is high in the cycle after an edge at which `valid_in` was high, and low after an edge at which it was low. Each accepted input gives exactly one pulse.
- R7: `result` changes only after an accepted input. Otherwise it holds its last value.
- R8: A synchronous active-high `rst` clears `valid_out` and `result` to zero and takes priority over `valid_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands are valid and captured at this edge |
| op_a | input | 128 | Four consecutive schedule words, oldest in bits 31:0 |
| op_b | input | 128 | Bits 31:0 hold the next word; bits 127:32 are unused |
| valid_out | output | 1 | One-cycle flag marking a new result |
| result | output | 128 | Four packed pre-schedule sums |

## Verification
Two events can fall in the same cycle: a reset and an accepted input. The bench provokes this by raising `rst` while `valid_in` is high with nonzero operands. It judges the outcome by expecting zero on both `valid_out` and `result` after that edge.

The bench also sends inputs back to back, so that a new capture lands in the same cycle in which the previous result is still being presented. Both the held value and the updated value are compared against the behavioural model at every clock.

// File: rtl/msg_presched_pkg.sv
package msg_presched_pkg;
    localparam int WORD_W = 32;
    localparam int ROT_LO = 7;
    localparam int ROT_HI = 18;
    localparam int SHR_N  = 3;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/presched_sigma0.sv
module presched_sigma0
    import msg_presched_pkg::*;
(
    input  word_t x_i,
    output word_t sig_o
);
    word_t rot_lo, rot_hi, shr;

    always_comb begin
        rot_lo = {x_i[ROT_LO-1:0], x_i[WORD_W-1:ROT_LO]};
        rot_hi = {x_i[ROT_HI-1:0], x_i[WORD_W-1:ROT_HI]};
        shr    = {{SHR_N{1'b0}}, x_i[WORD_W-1:SHR_N]};
        sig_o  = rot_lo ^ rot_hi ^ shr;
    end

    // R1: the rotations preserve parity, so the output parity equals the parity of the shifted part
    always_comb begin
        sigma_parity_chk: assert (^sig_o == ^x_i[WORD_W-1:SHR_N]);
    end
endmodule

// File: rtl/presched_lane.sv
module presched_lane
    import msg_presched_pkg::*;
(
    input  word_t w_cur_i,
    input  word_t w_next_i,
    output word_t sum_o
);
    word_t sig;

    presched_sigma0 sig_i (
        .x_i   (w_next_i),
        .sig_o (sig)
    );

    always_comb begin
        sum_o = w_cur_i + sig;
    end

    // R4: the low bit of a modular sum carries in nothing
    always_comb begin
        lane_lsb_chk: assert (sum_o[0] == (w_cur_i[0] ^ sig[0]));
    end
endmodule

// File: rtl/msg_presched4.sv
module msg_presched4
    import msg_presched_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      valid_in,
    input  logic [LANES*WORD_W-1:0]   op_a,
    input  logic [LANES*WORD_W-1:0]   op_b,
    output logic                      valid_out,
    output logic [LANES*WORD_W-1:0]   result
);
    localparam int VEC_W = LANES * WORD_W;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] res;
    } state_t;

    state_t state_d, state_q;
    logic [VEC_W-1:0] lane_sum_flat;
    logic unused_upper_b;

    assign unused_upper_b = ^op_b[VEC_W-1:WORD_W];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        word_t w_cur, w_next, w_sum;
        assign w_cur = op_a[g*WORD_W +: WORD_W];
        if (g < LANES - 1) begin : g_inner
            assign w_next = op_a[(g+1)*WORD_W +: WORD_W];
        end else begin : g_top
            assign w_next = op_b[WORD_W-1:0];
        end
        presched_lane lane_i (
            .w_cur_i  (w_cur),
            .w_next_i (w_next),
            .sum_o    (w_sum)
        );
        assign lane_sum_flat[g*WORD_W +: WORD_W] = w_sum;
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = valid_in;
        if (valid_in) begin
            state_d.res = lane_sum_flat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_out = state_q.valid;
    assign result    = state_q.res;

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    // R6
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> $stable(result));
endmodule

// File: tb/msg_presched4_tb_top.sv
`timescale 1ns/1ps
module msg_presched4_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         valid_in;
    logic [127:0] op_a, op_b;
    logic         valid_out;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic         m_valid;
    logic [127:0] m_res;
    logic [127:0] saved;

    always #4 clk = ~clk;

    msg_presched4 dut_i (
        .clk(clk), .rst(rst), .valid_in(valid_in),
        .op_a(op_a), .op_b(op_b),
        .valid_out(valid_out), .result(result)
    );

    function automatic logic [31:0] ref_sig0(input logic [31:0] x);
        logic [63:0] dbl;
        logic [31:0] r7, r18;
        dbl = {x, x};
        r7  = 32'(dbl >> 7);
        r18 = 32'(dbl >> 18);
        return r7 ^ r18 ^ (x >> 3);
    endfunction

    function automatic logic [127:0] ref_calc(input logic [127:0] a, input logic [127:0] b);
        logic [31:0] w [5];
        logic [127:0] r;
        for (int i = 0; i < 4; i++) w[i] = a[32*i +: 32];
        w[4] = b[31:0];
        for (int i = 0; i < 4; i++) r[32*i +: 32] = w[i] + ref_sig0(w[i+1]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, model the edge, compare at the next negedge
    task automatic step(input string tag, input logic r, input logic v,
                        input logic [127:0] a, input logic [127:0] b);
        rst = r; valid_in = v; op_a = a; op_b = b;
        if (r) begin
            m_valid = 1'b0; m_res = '0;
        end else begin
            m_valid = v;
            if (v) m_res = ref_calc(a, b);
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid (R6)"}, {127'd0, valid_out}, {127'd0, m_valid});
        check(tag, result, m_res);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; valid_in = 1'b0; op_a = '0; op_b = '0;
        m_valid = 1'b0; m_res = '0;
        @(negedge clk);
        step("R8 reset state", 1'b1, 1'b0, '0, '0);

        step("R2 zeros", 1'b0, 1'b1, '0, '0);
        step("R4 all ones wrap", 1'b0, 1'b1, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}});
        check("R4 all ones lane value", result, {4{32'h1FFFFFFE}});
        step("R7 hold idle", 1'b0, 1'b0, 128'h1234, 128'h5678);

        for (int k = 0; k < 32; k++) begin
            step("R1 R2 single bit", 1'b0, 1'b1, 128'd1 << (k * 4), 128'd1 << k);
        end
        for (int k = 0; k < 32; k++) begin
            step("R3 top lane bit", 1'b0, 1'b1, {32'h0, {3{32'hFFFFFFFF}}}, 128'd1 << k);
        end

        for (int k = 0; k < 60; k++) begin
            logic [127:0] a, b;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            step("R2 R3 random", 1'b0, (k % 3) != 2, a, b);
        end

        step("R5 base", 1'b0, 1'b1, 128'hA5A5A5A5_0F0F0F0F_12345678_DEADBEEF, 128'h0000_0000_0000_0000_0000_0000_CAFEF00D);
        saved = result;
        step("R5 upper b toggled", 1'b0, 1'b1, 128'hA5A5A5A5_0F0F0F0F_12345678_DEADBEEF, 128'hFFFF_FFFF_1357_9BDF_8888_7777_CAFEF00D);
        check("R5 upper b no effect", result, saved);

        step("R6 load", 1'b0, 1'b1, {4{32'h80000001}}, 128'h7);
        step("R8 reset with valid", 1'b1, 1'b1, {4{32'h80000001}}, 128'h7);
        check("R8 cleared result", result, '0);
        step("R6 after reset", 1'b0, 1'b1, {4{32'h00010002}}, 128'h3);
        step("R7 hold after pulse", 1'b0, 1'b0, '1, '1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule